// File: doc/BRIEF.md
# Sixteen-Bit Add/Subtract Coprocessor

This unit sits beside an 8-bit RISC core and gives it word-wide addition and subtraction. The core loads two 16-bit operands, a byte at a time, into operand registers that it reaches through its own 8-bit data bus. It then raises one of two command strobes from its instruction decoder. On the following clock edge the unit writes the 16-bit sum or difference into a result register and updates three status flags: carry, zero and digit carry. The core reads the result back as two bytes over the same bus.

The arithmetic is done by a carry-select adder cut into 4-bit sections. Each upper section works out its sum for both possible incoming carries, and the real carry picks one of the two. Subtraction adds the inverted second operand with a carry-in of one, so after a subtract the carry flag means "no borrow".

Top module: `word_arith_unit`

## Requirements
- R1: One clock edge after `cmd_add` is sampled high (with `cmd_sub` low), the result register holds (A + B) mod 65536 and `flag_c` holds the carry out of bit 15.
- R2: One clock edge after `cmd_sub` is sampled high, the result register holds (A + ~B + 1) mod 65536, which is A - B modulo 65536.
- R3: After a subtract, `flag_c` is 1 exactly when A >= B taken as unsigned numbers. After an add, it is the carry out of bit 15.
- R4: `flag_z` is 1 exactly when all 16 bits of the new result are 0.
- R5: `flag_dc` is the carry from bit 3 into bit 4 of the same addition, with the second operand inverted and a carry-in of 1 for a subtract.
- R6: A bus write (`bus_we` high) to address 0, 1, 2 or 3 loads A low byte, A high byte, B low byte or B high byte. The other byte of that operand keeps its value.
- R7: Reads are combinational. Address 0 to 3 return the operand bytes in the R6 order, 4 returns the result low byte, 5 returns the result high byte, and 6 or 7 return 0. Writes to addresses 4 to 7 change nothing.
- R8: While no command is asserted, the result register and all three flags keep their values, even when the operands are rewritten.
- R9: When `cmd_add` and `cmd_sub` are high in the same cycle, the unit subtracts.
- R10: `rst_n` low at a clock edge clears both operands, the result and all flags (synchronous, active low).
- R11: A command and an operand write in the same cycle use the operand value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_we | input | 1 | Byte write strobe |
| bus_addr | input | 3 | Byte register select |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte (combinational) |
| cmd_add | input | 1 | Add command from the host decoder |
| cmd_sub | input | 1 | Subtract command from the host decoder |
| flag_c | output | 1 | Carry / no-borrow flag |
| flag_z | output | 1 | Zero flag |
| flag_dc | output | 1 | Digit carry flag |

## Verification
Each result and flag is due one rising edge after the cycle in which the command is sampled. An operand byte is readable one edge after its write, and a bus read is valid within the same cycle as its address. The bench drives commands, writes and read addresses just after a falling edge. It samples at the next falling edge, after exactly one rising edge has passed, so every check falls in the cycle in which its value first becomes valid. Idle cycles before the hold and ignored-write checks show that nothing drifts after that point.

// File: rtl/calu_pkg.sv
// Package: shared constants for the 16-bit add/subtract coprocessor.
// Assumes a byte-wide host bus and a word exactly two bytes wide.
package calu_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;
    localparam int NIB_W  = 4;   // digit carry is taken out of this many low bits

    localparam logic [ADDR_W-1:0] SEL_A_LO = 3'd0;
    localparam logic [ADDR_W-1:0] SEL_A_HI = 3'd1;
    localparam logic [ADDR_W-1:0] SEL_B_LO = 3'd2;
    localparam logic [ADDR_W-1:0] SEL_B_HI = 3'd3;
    localparam logic [ADDR_W-1:0] SEL_R_LO = 3'd4;
    localparam logic [ADDR_W-1:0] SEL_R_HI = 3'd5;
endpackage

// File: rtl/csel_adder.sv
// Module: csel_adder
// Carry-select adder. Section 0 ripples with the true carry-in. Every higher
// section computes two sums (carry-in 0 and 1) and the incoming carry selects.
// Assumes W is a whole multiple of SEC_W.
module csel_adder #(
    parameter int W     = 16,
    parameter int SEC_W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int NSEC = W / SEC_W;

    logic [NSEC:0] carry;
    assign carry[0] = cin;

    for (genvar s = 0; s < NSEC; s++) begin : g_sec
        logic [SEC_W-1:0] a_s, b_s;
        assign a_s = a[s*SEC_W +: SEC_W];
        assign b_s = b[s*SEC_W +: SEC_W];
        if (s == 0) begin : g_first
            // first section: plain add with the real carry-in
            assign {carry[1], sum[SEC_W-1:0]} =
                {1'b0, a_s} + {1'b0, b_s} + (SEC_W+1)'(carry[0]);
        end else begin : g_select
            logic [SEC_W:0] pre0, pre1;
            // precomputed sums for both possible carry-ins
            assign pre0 = {1'b0, a_s} + {1'b0, b_s};
            assign pre1 = {1'b0, a_s} + {1'b0, b_s} + (SEC_W+1)'(1);
            // carry from below picks one of them
            assign {carry[s+1], sum[s*SEC_W +: SEC_W]} = carry[s] ? pre1 : pre0;
        end
    end

    assign cout = carry[NSEC];

    // R1: section selection must agree with a full-width sum
    always_comb begin
        a_r1_csel_equals_sum: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + (W+1)'(cin)));
    end
endmodule

// File: rtl/operand_regs.sv
// Module: operand_regs
// Holds operands A and B, each loaded one byte per bus write. Addresses
// outside the operand range are ignored. Synchronous active-low reset.
module operand_regs
    import calu_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [WORD_W-1:0] opa,
    output logic [WORD_W-1:0] opb
);
    // byte-wise loading of both operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opa <= '0;
            opb <= '0;
        end else if (we) begin
            case (addr)
                SEL_A_LO: opa[BYTE_W-1:0]      <= wdata;
                SEL_A_HI: opa[WORD_W-1:BYTE_W] <= wdata;
                SEL_B_LO: opb[BYTE_W-1:0]      <= wdata;
                SEL_B_HI: opb[WORD_W-1:BYTE_W] <= wdata;
                default: ;
            endcase
        end
    end

    a_r6_low_write_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == SEL_A_LO) |=> $stable(opa[WORD_W-1:BYTE_W]) && $stable(opb));
    a_r6_high_write_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == SEL_B_HI) |=> $stable(opb[BYTE_W-1:0]) && $stable(opa));
    a_r7_no_write_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (!we || addr >= SEL_R_LO) |=> $stable(opa) && $stable(opb));
endmodule

// File: rtl/result_unit.sv
// Module: result_unit
// Runs one add or subtract per command through the carry-select adder and
// registers the result with carry, zero and digit-carry flags. Subtract wins
// when both commands are high. Holds its state while no command is present.
module result_unit
    import calu_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int SEC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_add,
    input  logic              cmd_sub,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    output logic [WORD_W-1:0] res_q,
    output logic              c_q,
    output logic              z_q,
    output logic              dc_q
);
    logic              go;
    logic [WORD_W-1:0] b_eff;
    logic [WORD_W-1:0] sum;
    logic              cout;
    logic [NIB_W:0]    nib;

    assign go    = cmd_add | cmd_sub;
    assign b_eff = cmd_sub ? ~opb : opb;

    csel_adder #(.W(WORD_W), .SEC_W(SEC_W)) u_adder (
        .a   (opa),
        .b   (b_eff),
        .cin (cmd_sub),
        .sum (sum),
        .cout(cout)
    );

    // low-digit add for the carry out of bit 3
    assign nib = {1'b0, opa[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]} + (NIB_W+1)'(cmd_sub);

    // capture result and flags on a command, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            c_q   <= 1'b0;
            z_q   <= 1'b0;
            dc_q  <= 1'b0;
        end else if (go) begin
            res_q <= sum;
            c_q   <= cout;
            z_q   <= (sum == '0);
            dc_q  <= nib[NIB_W];
        end
    end

    a_r1_add_result: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_add && !cmd_sub) |=> ({c_q, res_q} == $past({1'b0, opa} + {1'b0, opb})));
    a_r2_sub_result: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_sub |=> (res_q == $past(opa - opb)));
    a_r3_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_sub |=> (c_q == $past(opa >= opb)));
    a_r4_zero_matches: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (z_q == (res_q == '0)));
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> $stable(res_q) && $stable(c_q) && $stable(z_q) && $stable(dc_q));
    a_r10_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (res_q == '0) && !c_q && !z_q && !dc_q);
endmodule

// File: rtl/word_arith_unit.sv
// Module: word_arith_unit (top)
// Byte-bus front end for the 16-bit add/subtract coprocessor: operand
// registers, the arithmetic/result stage and a combinational read mux.
// Assumes WORD_W is two bytes; unmapped addresses read as zero.
module word_arith_unit
    import calu_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int SEC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              cmd_add,
    input  logic              cmd_sub,
    output logic              flag_c,
    output logic              flag_z,
    output logic              flag_dc
);
    logic [WORD_W-1:0] opa, opb, res;

    operand_regs #(.WORD_W(WORD_W)) u_ops (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (bus_we),
        .addr (bus_addr),
        .wdata(bus_wdata),
        .opa  (opa),
        .opb  (opb)
    );

    result_unit #(.WORD_W(WORD_W), .SEC_W(SEC_W)) u_res (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_add(cmd_add),
        .cmd_sub(cmd_sub),
        .opa    (opa),
        .opb    (opb),
        .res_q  (res),
        .c_q    (flag_c),
        .z_q    (flag_z),
        .dc_q   (flag_dc)
    );

    // byte read-back mux
    always_comb begin
        case (bus_addr)
            SEL_A_LO: bus_rdata = opa[BYTE_W-1:0];
            SEL_A_HI: bus_rdata = opa[WORD_W-1:BYTE_W];
            SEL_B_LO: bus_rdata = opb[BYTE_W-1:0];
            SEL_B_HI: bus_rdata = opb[WORD_W-1:BYTE_W];
            SEL_R_LO: bus_rdata = res[BYTE_W-1:0];
            SEL_R_HI: bus_rdata = res[WORD_W-1:BYTE_W];
            default:  bus_rdata = '0;
        endcase
    end

    a_r7_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > SEL_R_HI) |-> (bus_rdata == '0));
endmodule

// File: tb/word_arith_unit_bench.sv
module word_arith_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       cmd_add = 1'b0;
    logic       cmd_sub = 1'b0;
    logic       flag_c, flag_z, flag_dc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    word_arith_unit u_word_arith_unit (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_add(cmd_add),
        .cmd_sub(cmd_sub), .flag_c(flag_c), .flag_z(flag_z), .flag_dc(flag_dc)
    );

    // {sub, A, B, result, c, z, dc}
    localparam logic [51:0] VECS [9] = '{
        {1'b0, 16'h1234, 16'h4321, 16'h5555, 1'b0, 1'b0, 1'b0},
        {1'b0, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 1'b1, 1'b1},
        {1'b0, 16'h00F8, 16'h0008, 16'h0100, 1'b0, 1'b0, 1'b1},
        {1'b1, 16'h5000, 16'h1000, 16'h4000, 1'b1, 1'b0, 1'b1},
        {1'b1, 16'h1000, 16'h2000, 16'hF000, 1'b0, 1'b0, 1'b1},
        {1'b1, 16'h0003, 16'h0005, 16'hFFFE, 1'b0, 1'b0, 1'b0},
        {1'b1, 16'hABCD, 16'hABCD, 16'h0000, 1'b1, 1'b1, 1'b1},
        {1'b0, 16'h7FFF, 16'h8000, 16'hFFFF, 1'b0, 1'b0, 1'b0},
        {1'b0, 16'h0F0F, 16'h0101, 16'h1010, 1'b0, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
        bus_addr = lo + 3'd1; #1; v[15:8] = bus_rdata;
        bus_addr = lo;        #1; v[7:0]  = bus_rdata;
    endtask

    task automatic load(input logic [15:0] a, input logic [15:0] b);
        wr(3'd0, a[7:0]); wr(3'd1, a[15:8]);
        wr(3'd2, b[7:0]); wr(3'd3, b[15:8]);
    endtask

    task automatic issue(input logic add, input logic sub);
        cmd_add = add; cmd_sub = sub;
        @(negedge clk);
        cmd_add = 1'b0; cmd_sub = 1'b0;
    endtask

    initial begin
        logic [15:0] v;
        logic        f_c, f_z, f_dc;
        repeat (3) @(negedge clk);
        // R10 reset state
        rd16(3'd4, v); chk("R10 result", v, 16'h0000);
        rd16(3'd0, v); chk("R10 opA", v, 16'h0000);
        chk("R10 flags", {13'd0, flag_c, flag_z, flag_dc}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 9; i++) begin
            logic [51:0] t;
            string rq;
            t = VECS[i];
            rq = t[51] ? "R2" : "R1";
            load(t[50:35], t[34:19]);
            issue(!t[51], t[51]);
            rd16(3'd4, v);
            chk(rq, v, t[18:3]);
            chk("R3 carry", {15'd0, flag_c}, {15'd0, t[2]});
            chk("R4 zero", {15'd0, flag_z}, {15'd0, t[1]});
            chk("R5 digit carry", {15'd0, flag_dc}, {15'd0, t[0]});
        end

        // R9 both commands -> subtract: 0x0010 - 0x0001
        load(16'h0010, 16'h0001);
        issue(1'b1, 1'b1);
        rd16(3'd4, v); chk("R9 result", v, 16'h000F);
        chk("R9 carry", {15'd0, flag_c}, 16'h0001);

        // R11 write of B low byte in the same cycle as an add uses old B (1)
        bus_we = 1'b1; bus_addr = 3'd2; bus_wdata = 8'h05; cmd_add = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; cmd_add = 1'b0;
        rd16(3'd4, v); chk("R11 old operand", v, 16'h0011);
        rd16(3'd2, v); chk("R11 new B", v, 16'h0005);

        // R8 hold while idle and while operands change
        f_c = flag_c; f_z = flag_z; f_dc = flag_dc;
        repeat (3) @(negedge clk);
        load(16'hFFFF, 16'hFFFF);
        repeat (2) @(negedge clk);
        rd16(3'd4, v); chk("R8 result held", v, 16'h0011);
        chk("R8 flags held", {13'd0, flag_c, flag_z, flag_dc}, {13'd0, f_c, f_z, f_dc});

        // R6 byte isolation
        wr(3'd1, 8'h12);
        rd16(3'd0, v); chk("R6 A high write", v, 16'h12FF);
        wr(3'd2, 8'h34);
        rd16(3'd2, v); chk("R6 B low write", v, 16'hFF34);

        // R7 writes to result/unmapped ignored, unmapped reads zero
        wr(3'd4, 8'hAA); wr(3'd5, 8'hBB); wr(3'd6, 8'hCC);
        rd16(3'd4, v); chk("R7 result not writable", v, 16'h0011);
        bus_addr = 3'd6; #1; chk("R7 addr6 reads 0", {8'd0, bus_rdata}, 16'h0000);
        bus_addr = 3'd7; #1; chk("R7 addr7 reads 0", {8'd0, bus_rdata}, 16'h0000);
        rd16(3'd0, v); chk("R7 operand A untouched", v, 16'h12FF);

        // R10 mid-run reset after a nonzero result with flags set
        load(16'hFFFF, 16'h0001);
        issue(1'b1, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd16(3'd4, v); chk("R10 result cleared", v, 16'h0000);
        rd16(3'd2, v); chk("R10 opB cleared", v, 16'h0000);
        chk("R10 flags cleared", {13'd0, flag_c, flag_z, flag_dc}, 16'h0000);

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule